// File: doc/BRIEF.md
# Load/Store Multiple Word Sequencer

This block lets a small in-order core run a block-transfer instruction. The instruction moves several consecutive registers to or from consecutive memory words. Upstream logic has already decoded the major opcode. It hands over the low 26 bits of the instruction word, the value of the base register and a one-cycle start strobe.

The sequencer then steps through the words one at a time. For each word it computes the register number and the byte address. It drives a request/ready memory port, and for stores it also drives a register-file read port. For loads it drives a register-file write port.

A one-cycle done pulse marks the end of a sequence. The sequencer refuses a misaligned start address in the aligned variant of the instruction. It also flags a load that overwrites the base register before the final word.

Top module: `lsm_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `mem_req`, `done`, `align_err`, `base_hazard` and `rf_we` are all low.
- R2: The effective start address is `base_val` plus a 9-bit signed offset. The offset's sign bit is instruction bit 15 and its low eight bits are instruction bits 7:0. Word k uses that start address plus 4*k, wrapping modulo 2^XLEN.
- R3: Instruction bits 14:12 give the number of words. The value 0 means eight words, and any other value n means n words. Words are issued in increasing k, from 0 up to count-1.
- R4: Instruction bit 11 selects the direction. With 0 (load), `mem_we` is low and each accepted word writes `mem_rdata` to the register file. With 1 (store), `mem_we` is high and `mem_wdata` carries `rf_rdata` for the register that `rf_raddr` selects.
- R5: The first register comes from instruction bits 25:21 (rt). Word k uses register ((rt + k) mod 32) OR (rt AND 16), so a run that starts at 16 or above wraps back to 16.
- R6: In a store whose rt field is 0, `rf_raddr` is 0 for every word and `mem_wdata` is zero for every word.
- R7: A load never asserts `rf_we` for register 0. A word mapped to register 0 still performs its memory handshake.
- R8: Each word's request stays asserted, with a stable address, until `mem_ready` is sampled high. Only then does the word index advance.
- R9: `done` is high for exactly the one cycle after the clock edge that accepts the last word. `busy` and `mem_req` are low in that cycle.
- R10: If instruction bits 10:8 equal 5, any address alignment is allowed. For any other value, a start address with nonzero bits 1:0 makes `align_err` pulse for one cycle after start. In that case no request is issued and no done is given.
- R11: In a load, `base_hazard` is high while a word is requested whose register equals the base register field (instruction bits 20:16), unless that word is the last one.
- R12: The base value and the start address are captured at start. Later changes on `base_val` do not move the addresses.
- R13: A start strobe that arrives while a sequence is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| instr | input | 26 | Low 26 bits of the instruction word |
| base_val | input | XLEN | Value of the base register |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory request for the current word |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | XLEN | Byte address of the current word |
| mem_wdata | output | XLEN | Store data |
| mem_ready | input | 1 | Memory accepts the current word |
| mem_rdata | input | XLEN | Load data, valid with `mem_ready` |
| rf_raddr | output | 5 | Register-file read select for stores |
| rf_rdata | input | XLEN | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write select |
| rf_wdata | output | XLEN | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | One-cycle misaligned-start pulse |
| base_hazard | output | 1 | Load overwrites the base register before the last word |

## Verification
The hardest situation to reach from the ports is a load whose register run wraps from 31 back to 16 and lands on the base register at a word that is not the last one. The stimulus picks rt near the top of the upper bank, so that the wrap itself produces the hazard.

A second such run puts the base register on the final word, so that the flag must stay low there.

Ready patterns that stall on alternate and irregular cycles keep requests waiting across several edges. During one such stall the bench pulses start again and alters `base_val`, to show that neither one disturbs the running sequence.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [0:0] {ST_IDLE, ST_RUN} lsm_state_e;

  typedef struct packed {
    logic [4:0] rt;
    logic [4:0] rs;
    logic       store;
    logic       unal;
    logic [3:0] cnt;
    logic [8:0] off;
  } lsm_fields_t;

  // Word count: field value zero stands for eight words.
  function automatic logic [3:0] lsm_count(input logic [2:0] f);
    return (f == 3'd0) ? 4'd8 : {1'b0, f};
  endfunction

  // Register for word k: wraps in 5 bits, the upper-bank bit stays set.
  function automatic logic [4:0] lsm_reg_at(input logic [4:0] rt, input logic [3:0] k);
    logic [4:0] sum;
    sum = rt + {1'b0, k};
    return sum | (rt & 5'h10);
  endfunction

endpackage

// File: rtl/lsm_decode.sv
module lsm_decode
  import lsm_pkg::*;
#(
  parameter logic [2:0] UA_MINOR = 3'd5
) (
  input  logic [25:0]  instr,
  output lsm_fields_t  fld
);
  always_comb begin
    fld.rt    = instr[25:21];
    fld.rs    = instr[20:16];
    fld.off   = {instr[15], instr[7:0]};
    fld.cnt   = lsm_count(instr[14:12]);
    fld.store = instr[11];
    fld.unal  = (instr[10:8] == UA_MINOR);
  end
endmodule

// File: rtl/lsm_agen.sv
module lsm_agen
  import lsm_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] ea_base,
  input  logic [4:0]      rt,
  input  logic [3:0]      k,
  output logic [XLEN-1:0] addr,
  output logic [4:0]      regnum
);
  function automatic logic [XLEN-1:0] word_addr(input logic [XLEN-1:0] b, input logic [3:0] idx);
    return b + XLEN'({idx, 2'b00});
  endfunction

  assign addr   = word_addr(ea_base, k);
  assign regnum = lsm_reg_at(rt, k);
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int         XLEN     = 32,
  parameter logic [2:0] UA_MINOR = 3'd5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [25:0]     instr,
  input  logic [XLEN-1:0] base_val,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [4:0]      rf_raddr,
  input  logic [XLEN-1:0] rf_rdata,
  output logic            rf_we,
  output logic [4:0]      rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic            done,
  output logic            align_err,
  output logic            base_hazard
);
  localparam int OFF_W = 9;

  lsm_fields_t     dec;
  lsm_state_e      state_q;
  logic [3:0]      k_q, cnt_q;
  logic [4:0]      rt_q, rs_q;
  logic            store_q, done_q, aerr_q;
  logic [XLEN-1:0] ea_q, start_ea;
  logic [4:0]      cur_reg;
  logic            misaligned, xfer_fire, xfer_last;

  lsm_decode #(.UA_MINOR(UA_MINOR)) u_dec (.instr(instr), .fld(dec));

  lsm_agen #(.XLEN(XLEN)) u_agen (
    .ea_base(ea_q), .rt(rt_q), .k(k_q), .addr(mem_addr), .regnum(cur_reg)
  );

  assign start_ea   = base_val + {{(XLEN-OFF_W){dec.off[OFF_W-1]}}, dec.off};
  assign misaligned = !dec.unal && (start_ea[1:0] != 2'b00);

  assign busy      = (state_q == ST_RUN);
  assign mem_req   = busy;
  assign mem_we    = store_q;
  assign xfer_fire = mem_req && mem_ready;
  assign xfer_last = (k_q == cnt_q - 4'd1);

  assign rf_raddr  = (rt_q == 5'd0) ? 5'd0 : cur_reg;
  assign mem_wdata = (store_q && rf_raddr != 5'd0) ? rf_rdata : '0;

  assign rf_we    = xfer_fire && !store_q && (cur_reg != 5'd0);
  assign rf_waddr = cur_reg;
  assign rf_wdata = mem_rdata;

  assign base_hazard = mem_req && !store_q && (cur_reg == rs_q) && !xfer_last;
  assign done        = done_q;
  assign align_err   = aerr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      cnt_q   <= 4'd1;
      rt_q    <= '0;
      rs_q    <= '0;
      store_q <= 1'b0;
      ea_q    <= '0;
      done_q  <= 1'b0;
      aerr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      aerr_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (misaligned) begin
              aerr_q <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              k_q     <= '0;
              cnt_q   <= dec.cnt;
              rt_q    <= dec.rt;
              rs_q    <= dec.rs;
              store_q <= dec.store;
              ea_q    <= start_ea;
            end
          end
        end
        ST_RUN: begin
          if (xfer_fire) begin
            if (xfer_last) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              k_q <= k_q + 4'd1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            mem_req,
  input logic            mem_ready,
  input logic            mem_we,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic [4:0]      rf_raddr,
  input logic            rf_we,
  input logic [4:0]      rf_waddr,
  input logic            done,
  input logic            align_err,
  input logic            base_hazard,
  input logic            xfer_last
);
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !xfer_last) |=> (mem_req && mem_addr == $past(mem_addr) + XLEN'(4)));

  p_zero_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && rf_raddr == 5'd0) |-> (mem_wdata == '0));

  p_no_r0_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != 5'd0 && mem_req && !mem_we));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(rf_waddr)));

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && xfer_last) |=> (done && !busy));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_align_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_req && !done));

  p_hazard_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    base_hazard |-> (mem_req && !mem_we && !xfer_last));
endmodule

bind lsm_seq lsm_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rf_raddr(rf_raddr),
  .rf_we(rf_we), .rf_waddr(rf_waddr), .done(done), .align_err(align_err),
  .base_hazard(base_hazard), .xfer_last(xfer_last)
);

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [25:0] instr = '0;
  logic [31:0] base_val = '0;
  logic        mem_ready = 1'b0;
  logic        busy, mem_req, mem_we, rf_we, done, align_err, base_hazard;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [4:0]  rf_raddr, rf_waddr;

  int n_chk = 0;
  int n_bad = 0;
  bit poke_phase = 1'b0;

  always #5 clk = ~clk;

  assign mem_rdata = mem_addr ^ 32'h5A5A_0000;
  assign rf_rdata  = 32'hC0DE_0000 | {27'd0, rf_raddr};

  lsm_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .base_val(base_val),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .done(done), .align_err(align_err), .base_hazard(base_hazard)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          m_busy, m_store, m_done, m_aerr;
  int          m_k, m_cnt, m_rt, m_rs;
  logic [31:0] m_ea;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_aerr = 0; m_k = 0; m_cnt = 1;
      m_rt = 0; m_rs = 0; m_store = 0; m_ea = '0;
    end else begin
      m_done = 0;
      m_aerr = 0;
      if (m_busy) begin
        if (mem_ready) begin
          m_k = m_k + 1;
          if (m_k == m_cnt) begin m_busy = 0; m_done = 1; end
        end
      end else if (start) begin
        logic [31:0] off;
        logic [31:0] ea;
        off = {{23{instr[15]}}, instr[15], instr[7:0]};
        ea  = base_val + off;
        if (instr[10:8] != 3'd5 && ea[1:0] != 2'b00) m_aerr = 1;
        else begin
          m_busy  = 1;
          m_k     = 0;
          m_cnt   = (instr[14:12] == 0) ? 8 : int'(instr[14:12]);
          m_rt    = int'(instr[25:21]);
          m_rs    = int'(instr[20:16]);
          m_store = instr[11];
          m_ea    = ea;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int e_reg;
      int e_rd;
      e_reg = ((m_rt + m_k) % 32) | (m_rt & 16);
      e_rd  = (m_rt == 0) ? 0 : e_reg;
      chk(poke_phase ? "R13" : "R3", "busy", 32'(busy), 32'(m_busy));
      chk("R8", "mem_req", 32'(mem_req), 32'(m_busy));
      chk("R9", "done", 32'(done), 32'(m_done));
      chk("R10", "align_err", 32'(align_err), 32'(m_aerr));
      chk("R11", "base_hazard", 32'(base_hazard),
          32'(m_busy && !m_store && e_reg == m_rs && m_k != m_cnt - 1));
      if (m_busy) begin
        chk(poke_phase ? "R12" : "R2", "mem_addr", mem_addr, m_ea + 32'(4 * m_k));
        chk("R4", "mem_we", 32'(mem_we), 32'(m_store));
        if (m_store) begin
          chk("R5", "rf_raddr", 32'(rf_raddr), 32'(e_rd));
          chk(m_rt == 0 ? "R6" : "R4", "mem_wdata", mem_wdata,
              (e_rd == 0) ? 32'd0 : (32'hC0DE_0000 | 32'(e_rd)));
        end else begin
          chk("R7", "rf_we", 32'(rf_we), 32'(mem_ready && e_reg != 0));
          if (mem_ready && e_reg != 0) begin
            chk("R5", "rf_waddr", 32'(rf_waddr), 32'(e_reg));
            chk("R4", "rf_wdata", rf_wdata, mem_addr ^ 32'h5A5A_0000);
          end
        end
      end else begin
        chk("R7", "rf_we idle", 32'(rf_we), 32'd0);
      end
    end
  end

  function automatic logic [25:0] mk(input int rt, input int rs, input int minor,
                                      input int st, input int cnt, input int off);
    logic [8:0] o;
    o = 9'(off);
    return {5'(rt), 5'(rs), o[8], 3'(cnt), 1'(st), 3'(minor), o[7:0]};
  endfunction

  function automatic bit rdy(input int mode, input int i);
    case (mode)
      0:       return 1'b1;
      1:       return i[0];
      default: return (i % 3) == 2;
    endcase
  endfunction

  task automatic run(input logic [25:0] ins, input logic [31:0] b, input int mode, input bit poke);
    @(posedge clk); #1;
    instr = ins; base_val = b; start = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      mem_ready = rdy(mode, i);
      if (poke && i == 1) begin
        // R13 / R12: second start and altered base during a stall
        start = 1'b1; base_val = ~b; instr = ins ^ 26'h0000_7000; poke_phase = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (!m_busy && i > 0) break;
    end
    mem_ready = 1'b0; start = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    poke_phase = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12;
    @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1", "busy in reset", 32'(busy), 32'd0);
    chk("R1", "mem_req in reset", 32'(mem_req), 32'd0);
    chk("R1", "done/aerr/hazard in reset", 32'({done, align_err, base_hazard, rf_we}), 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "quiet after reset", 32'({busy, mem_req, done, align_err, base_hazard}), 32'd0);

    run(mk(4, 29, 4, 0, 3, 8), 32'h0000_1000, 0, 0);      // R2 R4 plain load
    run(mk(28, 3, 4, 1, 0, 12), 32'h0000_2000, 1, 0);     // R3 R5 eight-word store, wrap to 16
    run(mk(0, 3, 4, 1, 4, 0), 32'h0000_3000, 2, 0);       // R6 store from register zero
    run(mk(0, 9, 4, 0, 3, 4), 32'h0000_3100, 1, 0);       // R7 load into register zero
    run(mk(30, 16, 4, 0, 5, 0), 32'h0000_4000, 2, 0);     // R11 hazard after wrap
    run(mk(30, 18, 4, 0, 5, 0), 32'h0000_4100, 0, 0);     // R11 base on last word: no flag
    run(mk(31, 31, 4, 0, 2, 0), 32'h0000_4200, 0, 0);     // R11 hazard on first word
    run(mk(8, 2, 4, 0, 2, -256), 32'h0000_5000, 0, 0);    // R2 negative offset
    run(mk(8, 2, 4, 0, 2, 0), 32'h0000_6002, 0, 0);       // R10 misaligned abort
    run(mk(8, 2, 5, 1, 3, 1), 32'h0000_6001, 1, 0);       // R10 unaligned variant runs
    run(mk(12, 2, 4, 1, 6, 4), 32'hFFFF_FFF0, 0, 0);      // R2 address wraps past top
    run(mk(10, 1, 4, 0, 4, 16), 32'h0000_7000, 1, 1);     // R12 R13 poke during run

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule